// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block sits between the frequency dividers of a clock generator and its output drivers. It gates three families of output clocks: a CPU family of differential pairs, a PCI family of single-ended clocks plus one normally free-running PCI clock, and a serial-reference (SRC) family of differential pairs. Each source clock arrives as a level that moves in step with the block clock `clk`. Two active-low stop pins, a software run bit, per-output stoppable bits and a set of remappable active-low clock-request inputs decide whether each output runs. Stopped differential pairs park with the true leg high and the complement leg low. Stopped single-ended clocks park low.

Every stop source is brought through a synchronizer. The run state of each output is held in its own gate register, and that register may change only while its source clock sits at the output's park level. The output level is therefore never cut short or stretched by a change of run state. An output whose enable bit is cleared drives both legs low.

Top module: `clkstop_top`

## Requirements
- R1: After reset, with no stop source active and all enables set, every CPU and SRC true leg equals its source clock, every complement leg equals its inverse, and every PCI output equals the PCI source clock.
- R2: While `cpuStopN` is low, every CPU output whose `cpuStopEn` bit is 1 parks with true high and complement low within 5 clock cycles. The stop pin passes through two synchronizer stages, so the output keeps following its source for the first 2 cycles.
- R3: A CPU output whose `cpuStopEn` bit is 0 keeps running while `cpuStopN` is low.
- R4: Within 5 cycles after `cpuStopN` returns high, the stopped CPU outputs follow their source clock again.
- R5: While `pciStopN` is low, all `pciOut` bits park low. `pcifOut` parks low only when `pcifStopEn` is 1 and runs otherwise.
- R6: When `srcStopEn` is 1, the PCI stop also parks every SRC pair with true high and complement low. When `srcStopEn` is 0, the PCI stop leaves the SRC pairs running.
- R7: `swRun` = 0 has the same effect as `pciStopN` low, and `swRun` = 1 has no effect.
- R8: Request input i is active when `reqN[i]` is 0 and `reqEn[i]` is 1. When active, it parks SRC pair (i mod 2) if `reqSel[i]` = 0, and SRC pair 2+2·(i mod 2) if `reqSel[i]` = 1. Request stops are ORed with all other stop sources.
- R9: Request inputs 0 and 1 share pins with PCI outputs 0 and 1. Each has no effect while the matching `pciOutEn` bit is 1.
- R10: An output whose enable bit is 0 drives true and complement (or its single leg) low, whatever its stop state.
- R11: A gated output changes level only in a cycle in which its source clock or its enable changes, so no short or stretched pulse is produced.
- R12: The true and complement legs of a pair are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; source clocks move in step with it |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuClkIn | input | 1 | CPU source clock level |
| pciClkIn | input | 1 | PCI source clock level |
| srcClkIn | input | 1 | SRC source clock level |
| cpuStopN | input | 1 | Active-low CPU stop pin |
| pciStopN | input | 1 | Active-low PCI/SRC stop pin |
| swRun | input | 1 | Software run bit, 0 acts as PCI stop |
| cpuStopEn | input | NUM_CPU | Per CPU output: 1 stoppable, 0 free running |
| cpuOutEn | input | NUM_CPU | Per CPU output enable |
| pciOutEn | input | NUM_PCI | Per PCI output enable |
| pcifStopEn | input | 1 | 1 lets the PCI stop halt the free-running PCI clock |
| pcifOutEn | input | 1 | Enable of the free-running PCI clock |
| srcStopEn | input | 1 | 1 lets the PCI stop halt the SRC pairs |
| srcOutEn | input | NUM_SRC | Per SRC pair enable |
| reqN | input | NUM_REQ | Active-low clock-request inputs |
| reqEn | input | NUM_REQ | Per request input enable |
| reqSel | input | NUM_REQ | Per request input target choice |
| cpuT | output | NUM_CPU | CPU true legs |
| cpuC | output | NUM_CPU | CPU complement legs |
| pciOut | output | NUM_PCI | PCI outputs |
| pcifOut | output | 1 | Free-running PCI output |
| srcT | output | NUM_SRC | SRC true legs |
| srcC | output | NUM_SRC | SRC complement legs |

## Verification
The hardest case to reach from the ports is a change of run state that lands against a particular phase of a slow or irregular source clock. That is where a careless gate would cut a pulse short. The bench drives the PCI source at half rate and the SRC source in an irregular two-of-three pattern. It toggles the stop pins at arbitrary cycles and watches each sample for an output edge with no source edge behind it. The request mapping is reached through random combinations of enable, select and shared-pin PCI enables, with the expected stopped set recomputed each time.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int NUM_CPU    = 2;
  localparam int NUM_PCI    = 4;
  localparam int NUM_SRC    = 5;
  localparam int NUM_REQ    = 4;
  localparam int NUM_SHARED = 2;   // request inputs that share a PCI output pin

  // Run strobes from control to datapath: 1 = output should run
  typedef struct packed {
    logic [NUM_CPU-1:0] cpuRun;
    logic [NUM_PCI-1:0] pciRun;
    logic               pcifRun;
    logic [NUM_SRC-1:0] srcRun;
  } runStrobe_t;

  // SRC pair stopped by request input idx for a given select value
  function automatic int reqTarget(input int idx, input logic sel);
    return sel ? (2 + 2 * (idx % 2)) : (idx % 2);
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuStopN,
  input  logic                  pciStopN,
  input  logic                  swRun,
  input  logic [NUM_CPU-1:0]    cpuStopEn,
  input  logic                  pcifStopEn,
  input  logic                  srcStopEn,
  input  logic [NUM_SHARED-1:0] pciShareOff,
  input  logic [NUM_REQ-1:0]    reqN,
  input  logic [NUM_REQ-1:0]    reqEn,
  input  logic [NUM_REQ-1:0]    reqSel,
  output runStrobe_t            strobe
);
  localparam int SYNC_W = NUM_REQ + 2;

  logic [SYNC_W-1:0]  rawN;
  logic [SYNC_W-1:0]  syncN;
  logic               cpuHalt;
  logic               pciHalt;
  logic [NUM_REQ-1:0] reqAct;
  logic [NUM_REQ-1:0] reqLive;
  logic [NUM_SRC-1:0] srcHit;

  assign rawN = {reqN, pciStopN, cpuStopN};

  clkstop_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({SYNC_W{1'b1}})
  ) syncI (
    .clk (clk),
    .rstN(rstN),
    .d   (rawN),
    .q   (syncN)
  );

  assign cpuHalt = ~syncN[0];
  assign pciHalt = ~syncN[1] | ~swRun;
  assign reqAct  = ~syncN[SYNC_W-1:2];

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      reqLive[i] = reqEn[i] & reqAct[i];
      if (i < NUM_SHARED) reqLive[i] = reqLive[i] & pciShareOff[i];
    end
    for (int j = 0; j < NUM_SRC; j++) begin
      srcHit[j] = 1'b0;
      for (int i = 0; i < NUM_REQ; i++) begin
        if (reqLive[i] && (reqTarget(i, reqSel[i]) == j)) srcHit[j] = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.cpuRun  = ~(cpuStopEn & {NUM_CPU{cpuHalt}});
    strobe.pciRun  = {NUM_PCI{~pciHalt}};
    strobe.pcifRun = ~(pcifStopEn & pciHalt);
    strobe.srcRun  = ~({NUM_SRC{srcStopEn & pciHalt}} | srcHit);
  end
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter logic PARK = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic srcClk,
  input  logic want,
  output logic run
);
  // The run state may only move while the source sits at the park level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               run <= 1'b1;
    else if (srcClk == PARK) run <= want;
  end
endmodule

// File: rtl/clkstop_dpath.sv
module clkstop_dpath
  import clkstop_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuClkIn,
  input  logic               pciClkIn,
  input  logic               srcClkIn,
  input  runStrobe_t         strobe,
  input  logic [NUM_CPU-1:0] cpuOutEn,
  input  logic [NUM_PCI-1:0] pciOutEn,
  input  logic               pcifOutEn,
  input  logic [NUM_SRC-1:0] srcOutEn,
  output logic [NUM_CPU-1:0] cpuT,
  output logic [NUM_CPU-1:0] cpuC,
  output logic [NUM_PCI-1:0] pciOut,
  output logic               pcifOut,
  output logic [NUM_SRC-1:0] srcT,
  output logic [NUM_SRC-1:0] srcC
);
  logic [NUM_CPU-1:0] cpuRunQ;
  logic [NUM_PCI-1:0] pciRunQ;
  logic               pcifRunQ;
  logic [NUM_SRC-1:0] srcRunQ;

  for (genvar k = 0; k < NUM_CPU; k++) begin : gCpu
    clkstop_gate #(.PARK(1'b1)) gateI (
      .clk(clk), .rstN(rstN), .srcClk(cpuClkIn),
      .want(strobe.cpuRun[k]), .run(cpuRunQ[k])
    );
    assign cpuT[k] = cpuOutEn[k] & (cpuRunQ[k] ? cpuClkIn : 1'b1);
    assign cpuC[k] = cpuOutEn[k] & cpuRunQ[k] & ~cpuClkIn;
  end

  for (genvar k = 0; k < NUM_PCI; k++) begin : gPci
    clkstop_gate #(.PARK(1'b0)) gateI (
      .clk(clk), .rstN(rstN), .srcClk(pciClkIn),
      .want(strobe.pciRun[k]), .run(pciRunQ[k])
    );
    assign pciOut[k] = pciOutEn[k] & pciRunQ[k] & pciClkIn;
  end

  clkstop_gate #(.PARK(1'b0)) pcifGateI (
    .clk(clk), .rstN(rstN), .srcClk(pciClkIn),
    .want(strobe.pcifRun), .run(pcifRunQ)
  );
  assign pcifOut = pcifOutEn & pcifRunQ & pciClkIn;

  for (genvar k = 0; k < NUM_SRC; k++) begin : gSrc
    clkstop_gate #(.PARK(1'b1)) gateI (
      .clk(clk), .rstN(rstN), .srcClk(srcClkIn),
      .want(strobe.srcRun[k]), .run(srcRunQ[k])
    );
    assign srcT[k] = srcOutEn[k] & (srcRunQ[k] ? srcClkIn : 1'b1);
    assign srcC[k] = srcOutEn[k] & srcRunQ[k] & ~srcClkIn;
  end
endmodule

// File: rtl/clkstop_top.sv
module clkstop_top
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuClkIn,
  input  logic               pciClkIn,
  input  logic               srcClkIn,
  input  logic               cpuStopN,
  input  logic               pciStopN,
  input  logic               swRun,
  input  logic [NUM_CPU-1:0] cpuStopEn,
  input  logic [NUM_CPU-1:0] cpuOutEn,
  input  logic [NUM_PCI-1:0] pciOutEn,
  input  logic               pcifStopEn,
  input  logic               pcifOutEn,
  input  logic               srcStopEn,
  input  logic [NUM_SRC-1:0] srcOutEn,
  input  logic [NUM_REQ-1:0] reqN,
  input  logic [NUM_REQ-1:0] reqEn,
  input  logic [NUM_REQ-1:0] reqSel,
  output logic [NUM_CPU-1:0] cpuT,
  output logic [NUM_CPU-1:0] cpuC,
  output logic [NUM_PCI-1:0] pciOut,
  output logic               pcifOut,
  output logic [NUM_SRC-1:0] srcT,
  output logic [NUM_SRC-1:0] srcC
);
  runStrobe_t strobe;

  clkstop_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrlI (
    .clk        (clk),
    .rstN       (rstN),
    .cpuStopN   (cpuStopN),
    .pciStopN   (pciStopN),
    .swRun      (swRun),
    .cpuStopEn  (cpuStopEn),
    .pcifStopEn (pcifStopEn),
    .srcStopEn  (srcStopEn),
    .pciShareOff(~pciOutEn[NUM_SHARED-1:0]),
    .reqN       (reqN),
    .reqEn      (reqEn),
    .reqSel     (reqSel),
    .strobe     (strobe)
  );

  clkstop_dpath dpathI (
    .clk      (clk),
    .rstN     (rstN),
    .cpuClkIn (cpuClkIn),
    .pciClkIn (pciClkIn),
    .srcClkIn (srcClkIn),
    .strobe   (strobe),
    .cpuOutEn (cpuOutEn),
    .pciOutEn (pciOutEn),
    .pcifOutEn(pcifOutEn),
    .srcOutEn (srcOutEn),
    .cpuT     (cpuT),
    .cpuC     (cpuC),
    .pciOut   (pciOut),
    .pcifOut  (pcifOut),
    .srcT     (srcT),
    .srcC     (srcC)
  );
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk
  import clkstop_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cpuClkIn,
  input logic               pciClkIn,
  input logic               srcClkIn,
  input logic               cpuStopN,
  input logic               pciStopN,
  input logic [NUM_CPU-1:0] cpuStopEn,
  input logic [NUM_CPU-1:0] cpuOutEn,
  input logic [NUM_PCI-1:0] pciOutEn,
  input logic [NUM_SRC-1:0] srcOutEn,
  input logic [NUM_CPU-1:0] cpuT,
  input logic [NUM_CPU-1:0] cpuC,
  input logic [NUM_PCI-1:0] pciOut,
  input logic [NUM_SRC-1:0] srcT,
  input logic [NUM_SRC-1:0] srcC
);
  localparam logic [3:0] SETTLE = 4'd7;

  logic [3:0] cpuLowCnt;
  logic [3:0] pciLowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuLowCnt <= '0;
      pciLowCnt <= '0;
    end else begin
      if (!cpuStopN && cpuStopEn[0]) cpuLowCnt <= (cpuLowCnt == 4'hF) ? cpuLowCnt : cpuLowCnt + 4'd1;
      else                           cpuLowCnt <= '0;
      if (!pciStopN) pciLowCnt <= (pciLowCnt == 4'hF) ? pciLowCnt : pciLowCnt + 4'd1;
      else           pciLowCnt <= '0;
    end
  end

  // R2: a held CPU stop parks stoppable output 0 true-high, complement-low
  a_r2_cpu_parks: assert property (@(posedge clk) disable iff (!rstN)
    (cpuLowCnt >= SETTLE && cpuOutEn[0]) |-> (cpuT[0] && !cpuC[0]));

  // R5: a held PCI stop parks PCI output 0 low
  a_r5_pci_low: assert property (@(posedge clk) disable iff (!rstN)
    (pciLowCnt >= SETTLE) |-> !pciOut[0]);

  // R11: no output edge without a source or enable edge
  a_r11_cpu_no_runt: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(cpuClkIn) && $stable(cpuOutEn)) |-> ($stable(cpuT) && $stable(cpuC)));

  a_r11_pci_no_runt: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(pciClkIn) && $stable(pciOutEn)) |-> $stable(pciOut));

  a_r11_src_no_runt: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(srcClkIn) && $stable(srcOutEn)) |-> ($stable(srcT) && $stable(srcC)));

  // R12: legs of a pair never high together
  a_r12_legs_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    ((cpuT & cpuC) == '0) && ((srcT & srcC) == '0));
endmodule

bind clkstop_top clkstop_chk chkI (
  .clk(clk), .rstN(rstN), .cpuClkIn(cpuClkIn), .pciClkIn(pciClkIn),
  .srcClkIn(srcClkIn), .cpuStopN(cpuStopN), .pciStopN(pciStopN),
  .cpuStopEn(cpuStopEn), .cpuOutEn(cpuOutEn), .pciOutEn(pciOutEn),
  .srcOutEn(srcOutEn), .cpuT(cpuT), .cpuC(cpuC), .pciOut(pciOut),
  .srcT(srcT), .srcC(srcC)
);

// File: tb/clkstop_top_tb_top.sv
module clkstop_top_tb_top;
  import clkstop_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuClkIn = 1'b0, pciClkIn = 1'b0, srcClkIn = 1'b0;
  logic cpuStopN = 1'b1, pciStopN = 1'b1, swRun = 1'b1;
  logic [NUM_CPU-1:0] cpuStopEn = '1, cpuOutEn = '1;
  logic [NUM_PCI-1:0] pciOutEn = '1;
  logic pcifStopEn = 1'b0, pcifOutEn = 1'b1, srcStopEn = 1'b0;
  logic [NUM_SRC-1:0] srcOutEn = '1;
  logic [NUM_REQ-1:0] reqN = '1, reqEn = '0, reqSel = '0;
  logic [NUM_CPU-1:0] cpuT, cpuC;
  logic [NUM_PCI-1:0] pciOut;
  logic pcifOut;
  logic [NUM_SRC-1:0] srcT, srcC;

  int nChecks = 0;
  int nErrors = 0;
  int phCnt = 0;

  clkstop_top dut_i (
    .clk(clk), .rstN(rstN), .cpuClkIn(cpuClkIn), .pciClkIn(pciClkIn),
    .srcClkIn(srcClkIn), .cpuStopN(cpuStopN), .pciStopN(pciStopN),
    .swRun(swRun), .cpuStopEn(cpuStopEn), .cpuOutEn(cpuOutEn),
    .pciOutEn(pciOutEn), .pcifStopEn(pcifStopEn), .pcifOutEn(pcifOutEn),
    .srcStopEn(srcStopEn), .srcOutEn(srcOutEn), .reqN(reqN), .reqEn(reqEn),
    .reqSel(reqSel), .cpuT(cpuT), .cpuC(cpuC), .pciOut(pciOut),
    .pcifOut(pcifOut), .srcT(srcT), .srcC(srcC)
  );

  always #10 clk = ~clk;

  // Source clocks: CPU full rate, PCI half rate, SRC irregular
  initial begin
    forever begin
      @(negedge clk);
      phCnt++;
      cpuClkIn = ~cpuClkIn;
      if (phCnt % 2 == 0) pciClkIn = ~pciClkIn;
      if (phCnt % 3 != 0) srcClkIn = ~srcClkIn;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    report();
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // ---- reference model from the requirements ----
  function automatic logic pciHaltExp();
    return !pciStopN || !swRun;
  endfunction

  function automatic logic [NUM_CPU-1:0] cpuRunExp();
    for (int k = 0; k < NUM_CPU; k++) cpuRunExp[k] = !(cpuStopEn[k] && !cpuStopN);
  endfunction

  function automatic logic [NUM_SRC-1:0] srcRunExp();
    logic [NUM_SRC-1:0] hit = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      logic live = reqEn[i] && !reqN[i] && !(i < NUM_SHARED && pciOutEn[i]);
      int tgt = reqSel[i] ? 2 + 2 * (i % 2) : i % 2;
      if (live) hit[tgt] = 1'b1;
    end
    for (int j = 0; j < NUM_SRC; j++) srcRunExp[j] = !((srcStopEn && pciHaltExp()) || hit[j]);
  endfunction

  function automatic logic [NUM_CPU-1:0] expCpuT();
    logic [NUM_CPU-1:0] r = cpuRunExp();
    for (int k = 0; k < NUM_CPU; k++) expCpuT[k] = cpuOutEn[k] & (r[k] ? cpuClkIn : 1'b1);
  endfunction
  function automatic logic [NUM_CPU-1:0] expCpuC();
    logic [NUM_CPU-1:0] r = cpuRunExp();
    for (int k = 0; k < NUM_CPU; k++) expCpuC[k] = cpuOutEn[k] & r[k] & !cpuClkIn;
  endfunction
  function automatic logic [NUM_SRC-1:0] expSrcT();
    logic [NUM_SRC-1:0] r = srcRunExp();
    for (int k = 0; k < NUM_SRC; k++) expSrcT[k] = srcOutEn[k] & (r[k] ? srcClkIn : 1'b1);
  endfunction
  function automatic logic [NUM_SRC-1:0] expSrcC();
    logic [NUM_SRC-1:0] r = srcRunExp();
    for (int k = 0; k < NUM_SRC; k++) expSrcC[k] = srcOutEn[k] & r[k] & !srcClkIn;
  endfunction
  function automatic logic [NUM_PCI-1:0] expPci();
    return pciOutEn & {NUM_PCI{!pciHaltExp() & pciClkIn}};
  endfunction
  function automatic logic expPcif();
    return pcifOutEn & !(pcifStopEn && pciHaltExp()) & pciClkIn;
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Compare all outputs with the model over 8 samples
  task automatic sampleCheck(input string tag);
    bit okCt = 1, okCc = 1, okP = 1, okF = 1, okSt = 1, okSc = 1;
    logic [31:0] aCt = 0, eCt = 0, aCc = 0, eCc = 0, aP = 0, eP = 0;
    logic [31:0] aF = 0, eF = 0, aSt = 0, eSt = 0, aSc = 0, eSc = 0;
    repeat (8) begin
      @(negedge clk); #5;
      if (cpuT !== expCpuT()) begin okCt = 0; aCt = 32'(cpuT); eCt = 32'(expCpuT()); end
      if (cpuC !== expCpuC()) begin okCc = 0; aCc = 32'(cpuC); eCc = 32'(expCpuC()); end
      if (pciOut !== expPci()) begin okP = 0; aP = 32'(pciOut); eP = 32'(expPci()); end
      if (pcifOut !== expPcif()) begin okF = 0; aF = 32'(pcifOut); eF = 32'(expPcif()); end
      if (srcT !== expSrcT()) begin okSt = 0; aSt = 32'(srcT); eSt = 32'(expSrcT()); end
      if (srcC !== expSrcC()) begin okSc = 0; aSc = 32'(srcC); eSc = 32'(expSrcC()); end
    end
    check(okCt, {tag, " R2 R3 R10 cpu true legs"}, aCt, eCt);
    check(okCc, {tag, " R2 R3 R10 cpu complement legs"}, aCc, eCc);
    check(okP,  {tag, " R5 R7 R10 pci outputs"}, aP, eP);
    check(okF,  {tag, " R5 free-running pci output"}, aF, eF);
    check(okSt, {tag, " R6 R8 R9 src true legs"}, aSt, eSt);
    check(okSc, {tag, " R6 R8 R9 src complement legs"}, aSc, eSc);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    settle(5);
    rstN = 1'b1;
    settle(4);

    // R1: reset state, everything running
    sampleCheck("R1 reset");

    // R3: free-running CPU output 0, stoppable output 1
    @(negedge clk); cpuStopEn = 2'b10; cpuStopN = 1'b0;
    settle(12); sampleCheck("R3 free-running");
    @(negedge clk); cpuStopN = 1'b1; cpuStopEn = '1;
    settle(12);

    // R2: minimum and maximum stop latency on CPU output 0
    begin
      bit early = 1, late = 1;
      logic [1:0] lastA = 0;
      @(negedge clk); cpuStopN = 1'b0; #5;
      for (int k = 0; k < 9; k++) begin
        if (k > 0) begin @(negedge clk); #5; end
        if (k <= 2 && cpuT[0] !== cpuClkIn) begin early = 0; lastA = {cpuT[0], cpuC[0]}; end
        if (k >= 5 && {cpuT[0], cpuC[0]} !== 2'b10) begin late = 0; lastA = {cpuT[0], cpuC[0]}; end
      end
      check(early, "R2 output keeps running for two cycles after stop", 32'(lastA), 32'(cpuClkIn));
      check(late, "R2 parked true-high complement-low within 5 cycles", 32'(lastA), 32'h2);
    end

    // R4: resume within 5 cycles
    begin
      bit ok = 1;
      logic lastA = 0, lastE = 0;
      @(negedge clk); cpuStopN = 1'b1; #5;
      for (int k = 0; k < 9; k++) begin
        if (k > 0) begin @(negedge clk); #5; end
        if (k >= 5 && cpuT[0] !== cpuClkIn) begin ok = 0; lastA = cpuT[0]; lastE = cpuClkIn; end
      end
      check(ok, "R4 cpu output resumes", 32'(lastA), 32'(lastE));
    end

    // R11: no pci edge without a source edge across stop and restart
    begin
      bit ok = 1;
      logic [NUM_PCI-1:0] prevOut;
      logic prevClk, prevF;
      logic [NUM_SRC-1:0] prevSrcT;
      logic prevSrcClk;
      pcifStopEn = 1'b1; srcStopEn = 1'b1;
      @(negedge clk); #5;
      prevOut = pciOut; prevClk = pciClkIn; prevF = pcifOut;
      prevSrcT = srcT; prevSrcClk = srcClkIn;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (k == 3 || k == 20) pciStopN = 1'b0;
        if (k == 11 || k == 29) pciStopN = 1'b1;
        #5;
        if ((pciOut !== prevOut || pcifOut !== prevF) && pciClkIn === prevClk) ok = 0;
        if (srcT !== prevSrcT && srcClkIn === prevSrcClk) ok = 0;
        prevOut = pciOut; prevClk = pciClkIn; prevF = pcifOut;
        prevSrcT = srcT; prevSrcClk = srcClkIn;
      end
      check(ok, "R11 output edge without source edge", 32'(ok), 32'h1);
      pcifStopEn = 1'b0; srcStopEn = 1'b0;
      settle(10);
    end

    // R5 R6: PCI stop with SRC stoppable and free-running PCI clock kept running
    @(negedge clk); pciStopN = 1'b0; srcStopEn = 1'b1;
    settle(12); sampleCheck("R5 R6 pci stop");
    @(negedge clk); pciStopN = 1'b1; srcStopEn = 1'b0;
    settle(12);

    // R7: software bit acts like the stop pin
    @(negedge clk); swRun = 1'b0; pcifStopEn = 1'b1;
    settle(12); sampleCheck("R7 software stop");
    check(pciOut === '0, "R7 pci low under software stop", 32'(pciOut), 0);
    @(negedge clk); swRun = 1'b1; pcifStopEn = 1'b0;
    settle(12);

    // R9: shared request pin 0 ignored while PCI output 0 enabled
    @(negedge clk); reqEn = 4'b0001; reqN = 4'b1110; reqSel = '0;
    settle(12); sampleCheck("R9 shared pin ignored");
    @(negedge clk); pciOutEn[0] = 1'b0;
    settle(12); sampleCheck("R8 R9 request on src0");
    // R8: request 1 with select set reaches SRC4
    @(negedge clk); reqEn = 4'b0010; reqN = 4'b1101; reqSel = 4'b0010; pciOutEn = 4'b1101;
    settle(12); sampleCheck("R8 request to src4");
    check(srcC[4] === 1'b0, "R8 src4 complement parked low", 32'(srcC[4]), 0);

    // R10: disabled outputs low regardless of stop
    @(negedge clk); cpuOutEn = 2'b01; srcOutEn = 5'b01111; pciOutEn = '0; cpuStopN = 1'b0;
    settle(12); sampleCheck("R10 disabled");
    check({cpuT[1], cpuC[1]} === 2'b00, "R10 disabled cpu pair low", 32'({cpuT[1], cpuC[1]}), 0);
    @(negedge clk); cpuOutEn = '1; srcOutEn = '1; pciOutEn = '1; cpuStopN = 1'b1;
    reqEn = '0; reqN = '1; reqSel = '0;
    settle(12);

    // Random scenarios
    for (int s = 0; s < 30; s++) begin
      @(negedge clk);
      cpuStopN   = 1'($urandom);
      pciStopN   = 1'($urandom);
      swRun      = ($urandom % 4) != 0;
      cpuStopEn  = NUM_CPU'($urandom);
      cpuOutEn   = NUM_CPU'($urandom | $urandom);
      pciOutEn   = NUM_PCI'($urandom);
      pcifStopEn = 1'($urandom);
      pcifOutEn  = ($urandom % 4) != 0;
      srcStopEn  = 1'($urandom);
      srcOutEn   = NUM_SRC'($urandom | $urandom);
      reqN       = NUM_REQ'($urandom);
      reqEn      = NUM_REQ'($urandom);
      reqSel     = NUM_REQ'($urandom);
      settle(12);
      sampleCheck("random");
    end

    // R12: legs exclusive over a mixed run
    begin
      bit ok = 1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk); #5;
        if ((cpuT & cpuC) !== '0 || (srcT & srcC) !== '0) ok = 0;
      end
      check(ok, "R12 both legs high", 32'(ok), 32'h1);
    end

    report();
  end
endmodule